// File: doc/BRIEF.md
# Pin Activity Capture Engine

This block watches a single input pin and turns what happens on it into a stream of 32-bit words for system memory. It has two capture modes. In stamp mode, every rising or falling transition of the pin stores the value of a free-running cycle counter. In sample mode, each cycle with the sample strobe high adds one bit holding the pin level, and every 32 such bits form one word.

Words go into a 64-byte staging store that is split into two halves of eight words each. One half fills while the other drains. A drain port with a valid/ready handshake sends out a half only after that half is complete. The destination is a small ring of software buffers. Each buffer has a full flag that the block sets after it has sent out a fixed number of words to that buffer. Software clears the flag to give the buffer back.

There are two independent sticky error flags. One reports that the staging store had no room for a word. The other reports that no destination buffer was free. Each error stops capture and discards incoming activity, and each has its own rule for when capture resumes. The sample clock is intended to stay at or below 108 MHz. That limit is a system constraint only and has no effect on the logic.

Top module: `pin_capture_engine`

## Requirements
- R1: In stamp mode (sample_mode = 0) with capture enabled, every change of level on pin_in produces one word. The pin first passes through a two-flop synchronizer. The word holds a free-running 32-bit cycle counter that wraps on overflow. The difference between two consecutive words therefore equals the number of clock cycles between the two transitions.
- R2: In sample mode (sample_mode = 1), each cycle with sample_en high takes one bit, the synchronized pin level. The first bit taken lands in bit 0 of the word. The 32nd bit completes the word.
- R3: The staging store holds 16 words as two halves of 8 words. mem_valid goes high only once a whole half is complete. Words leave in the order they were captured.
- R4: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_data does not change. A word is transferred in each cycle where both are high.
- R5: After BUF_WORDS (16) words have been transferred, the block sets the full flag of the current buffer and moves to the next buffer in round-robin order. Buffer 0 is used first. No word is offered while the current buffer's flag is set.
- R6: A one-cycle high on bit b of buf_release clears buf_full[b].
- R7: If a word is produced while both halves are full, int_ovf is set and that word is dropped. Every further word is also dropped until both halves have drained. Capture then resumes without any software action.
- R8: If a word is produced while the current buffer's full flag is set, buf_ovf is set and that word is dropped. Every further word is also dropped until software releases that buffer.
- R9: int_ovf and buf_ovf stay set until a one-cycle high on int_ovf_clr or buf_ovf_clr, respectively. If a new error and its clear arrive in the same cycle, the flag stays set.
- R10: While capture_en is low, pin transitions and sample strobes produce no words.
- R11: After reset, mem_valid, int_ovf, buf_ovf and every buf_full bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Monitored pin, asynchronous to clk |
| capture_en | input | 1 | Enables capture |
| sample_mode | input | 1 | 0 = stamp mode, 1 = sample mode |
| sample_en | input | 1 | Sample strobe used in sample mode |
| mem_valid | output | 1 | A drain word is offered |
| mem_data | output | WORD_W | The word being offered |
| mem_ready | input | 1 | The memory side accepts the word |
| buf_full | output | NBUF | Per-buffer full flags |
| buf_release | input | NBUF | Write-one pulses that give buffers back |
| int_ovf | output | 1 | Sticky flag: staging store had no room |
| int_ovf_clr | input | 1 | Clears int_ovf |
| buf_ovf | output | 1 | Sticky flag: no destination buffer was free |
| buf_ovf_clr | input | 1 | Clears buf_ovf |

## Verification
The assertions assume that buf_release only pulses buffers whose flags are set. They also assume that mem_ready is driven independently of the design, and that each clear input is a single-cycle pulse. The stimulus holds the pin at each level for several cycles, so every transition passes the synchronizer and is counted once. It changes mem_ready just after a clock edge. Buffer releases come either from a process that answers set flags or from directed pulses while that process is paused.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic {
    MODE_STAMP  = 1'b0,
    MODE_SAMPLE = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic edge_det
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      last <= sh[STAGES-1];
    end
  end

  assign level    = sh[STAGES-1];
  assign edge_det = sh[STAGES-1] ^ last;
endmodule

// File: rtl/pcap_packer.sv
module pcap_packer
  import pcap_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  cap_mode_e    mode,
  input  logic         accept,
  input  logic         edge_det,
  input  logic         level,
  input  logic         sample_en,
  input  logic [W-1:0] stamp,
  output logic         word_valid,
  output logic [W-1:0] word
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     acc;
  logic [CNT_W-1:0] cnt;
  logic             take_bit;
  logic             last_bit;

  assign take_bit = accept && (mode == MODE_SAMPLE) && sample_en;
  assign last_bit = (cnt == CNT_W'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cnt <= '0;
    end else if (take_bit) begin
      acc <= {level, acc[W-1:1]};
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    if (mode == MODE_STAMP) begin
      word_valid = accept && edge_det;
      word       = stamp;
    end else begin
      word_valid = take_bit && last_bit;
      word       = {level, acc[W-1:1]};
    end
  end
endmodule

// File: rtl/pcap_stage.sv
module pcap_stage #(
  parameter int W          = 32,
  parameter int HALF_WORDS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         room,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_take,
  output logic         empty,
  output logic         full_both
);
  localparam int IDX_W = $clog2(HALF_WORDS);
  localparam int DEPTH = 2 * HALF_WORDS;

  logic [W-1:0]     mem [DEPTH];
  logic             wr_half, rd_half;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [1:0]       half_full;
  logic             wr_last, rd_last;

  assign wr_last   = (wr_idx == IDX_W'(HALF_WORDS - 1));
  assign rd_last   = (rd_idx == IDX_W'(HALF_WORDS - 1));
  assign room      = !half_full[wr_half];
  assign rd_valid  = half_full[rd_half];
  assign rd_data   = mem[{rd_half, rd_idx}];
  assign empty     = (half_full == 2'b00);
  assign full_both = &half_full;

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_half, wr_idx}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_half   <= 1'b0;
      rd_half   <= 1'b0;
      wr_idx    <= '0;
      rd_idx    <= '0;
      half_full <= 2'b00;
    end else begin
      if (wr_en) begin
        wr_idx <= wr_idx + 1'b1;
        if (wr_last) wr_half <= ~wr_half;
      end
      if (rd_take) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_last) rd_half <= ~rd_half;
      end
      for (int h = 0; h < 2; h++) begin
        if (wr_en && wr_last && (wr_half == 1'(h)))
          half_full[h] <= 1'b1;
        else if (rd_take && rd_last && (rd_half == 1'(h)))
          half_full[h] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pin_capture_engine.sv
module pin_capture_engine
  import pcap_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int STAGE_BYTES = 64,
  parameter int NBUF        = 2,
  parameter int BUF_WORDS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic              capture_en,
  input  logic              sample_mode,
  input  logic              sample_en,
  output logic              mem_valid,
  output logic [WORD_W-1:0] mem_data,
  input  logic              mem_ready,
  output logic [NBUF-1:0]   buf_full,
  input  logic [NBUF-1:0]   buf_release,
  output logic              int_ovf,
  input  logic              int_ovf_clr,
  output logic              buf_ovf,
  input  logic              buf_ovf_clr
);
  localparam int STAGE_WORDS = STAGE_BYTES * 8 / WORD_W;
  localparam int HALF_WORDS  = STAGE_WORDS / 2;
  localparam int BUF_IDX_W   = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int BCNT_W      = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  logic [WORD_W-1:0]    stamp;
  logic                 level, edge_det;
  logic                 word_valid;
  logic [WORD_W-1:0]    word;
  logic                 room, rd_valid, empty, stage_full;
  logic                 halt_int, halt_buf, accept, blocked;
  logic                 wr_en, take, iovf_ev, bovf_ev;
  logic [BUF_IDX_W-1:0] cur_buf;
  logic [BCNT_W-1:0]    bcnt;
  logic                 buf_done;

  pcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .level(level), .edge_det(edge_det)
  );

  pcap_packer #(.W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .mode(cap_mode_e'(sample_mode)), .accept(accept),
    .edge_det(edge_det), .level(level), .sample_en(sample_en), .stamp(stamp),
    .word_valid(word_valid), .word(word)
  );

  pcap_stage #(.W(WORD_W), .HALF_WORDS(HALF_WORDS)) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(word), .room(room),
    .rd_valid(rd_valid), .rd_data(mem_data), .rd_take(take),
    .empty(empty), .full_both(stage_full)
  );

  assign blocked   = buf_full[cur_buf];
  assign accept    = capture_en && !halt_int && !halt_buf;
  assign bovf_ev   = word_valid && blocked;
  assign iovf_ev   = word_valid && !blocked && !room;
  assign wr_en     = word_valid && !blocked && room;
  assign mem_valid = rd_valid && !blocked;
  assign take      = mem_valid && mem_ready;
  assign buf_done  = take && (bcnt == BCNT_W'(BUF_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp    <= '0;
      halt_int <= 1'b0;
      halt_buf <= 1'b0;
      int_ovf  <= 1'b0;
      buf_ovf  <= 1'b0;
    end else begin
      stamp    <= stamp + 1'b1;
      halt_int <= iovf_ev | (halt_int & !empty);
      halt_buf <= bovf_ev | (halt_buf & blocked);
      int_ovf  <= iovf_ev | (int_ovf & !int_ovf_clr);
      buf_ovf  <= bovf_ev | (buf_ovf & !buf_ovf_clr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_buf <= '0;
      bcnt    <= '0;
    end else if (take) begin
      if (buf_done) begin
        bcnt    <= '0;
        cur_buf <= (cur_buf == BUF_IDX_W'(NBUF - 1)) ? '0 : cur_buf + 1'b1;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst)
        buf_full[b] <= 1'b0;
      else if (buf_done && (cur_buf == BUF_IDX_W'(b)))
        buf_full[b] <= 1'b1;
      else if (buf_release[b])
        buf_full[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/pcap_checker.sv
module pcap_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         mem_valid,
  input logic         mem_ready,
  input logic [W-1:0] mem_data,
  input logic         int_ovf,
  input logic         int_ovf_clr,
  input logic         buf_ovf,
  input logic         buf_ovf_clr,
  input logic         stage_full,
  input logic         blocked
);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data)));

  p_sticky_int_r9: assert property (@(posedge clk) disable iff (rst)
    (int_ovf && !int_ovf_clr) |=> int_ovf);

  p_sticky_buf_r9: assert property (@(posedge clk) disable iff (rst)
    (buf_ovf && !buf_ovf_clr) |=> buf_ovf);

  p_int_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(int_ovf) |-> $past(stage_full));

  p_buf_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_ovf) |-> $past(blocked));
endmodule

bind pin_capture_engine pcap_checker #(.W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_data(mem_data), .int_ovf(int_ovf), .int_ovf_clr(int_ovf_clr),
  .buf_ovf(buf_ovf), .buf_ovf_clr(buf_ovf_clr), .stage_full(stage_full),
  .blocked(blocked)
);

// File: tb/pin_capture_engine_bench.sv
module pin_capture_engine_bench;
  localparam int CLK_P = 10;
  localparam logic [31:0] SAMPLE_VEC [8] = '{
    32'h0000_0001, 32'h8000_0000, 32'hA5A5_5A5A, 32'hFFFF_0000,
    32'h1234_5678, 32'h0F0F_F0F0, 32'hDEAD_BEEF, 32'h7FFF_FFFE
  };
  localparam int GAP_VEC [8] = '{5, 9, 4, 17, 6, 12, 7, 20};

  logic clk = 1'b0, rst = 1'b1;
  logic pin_in = 1'b0, capture_en = 1'b0, sample_mode = 1'b0, sample_en = 1'b0;
  logic mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_data;
  logic [1:0] buf_full, buf_release;
  logic int_ovf, buf_ovf, int_ovf_clr = 1'b0, buf_ovf_clr = 1'b0;

  int nchk = 0, nfail = 0, ngot = 0, ready_mode = 0, rcnt = 0;
  logic auto_rel = 1'b1;
  logic [1:0] man_rel = 2'b00;
  logic [31:0] got [64];

  pin_capture_engine u_pin_capture_engine (
    .clk(clk), .rst(rst), .pin_in(pin_in), .capture_en(capture_en),
    .sample_mode(sample_mode), .sample_en(sample_en), .mem_valid(mem_valid),
    .mem_data(mem_data), .mem_ready(mem_ready), .buf_full(buf_full),
    .buf_release(buf_release), .int_ovf(int_ovf), .int_ovf_clr(int_ovf_clr),
    .buf_ovf(buf_ovf), .buf_ovf_clr(buf_ovf_clr)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    rcnt = rcnt + 1;
    mem_ready = (ready_mode == 1) || (ready_mode == 2 && rcnt[1:0] != 2'b00);
  end

  always @(negedge clk) begin
    buf_release = (auto_rel ? buf_full : 2'b00) | man_rel;
    if (rst) ngot = 0;
    else if (mem_valid && mem_ready && ngot < 64) begin
      got[ngot] = mem_data;
      ngot = ngot + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    pin_in = 1'b0; capture_en = 1'b0; sample_en = 1'b0;
    int_ovf_clr = 1'b0; buf_ovf_clr = 1'b0; man_rel = 2'b00;
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic push_sample(input logic b);
    pin_in = b;
    tick(3);
    sample_en = 1'b1;
    tick(1);
    sample_en = 1'b0;
  endtask

  task automatic toggle(input int gap);
    pin_in = ~pin_in;
    tick(gap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    check(mem_valid == 1'b0, "R11 mem_valid", 32'(mem_valid), 0);
    check(int_ovf == 1'b0, "R11 int_ovf", 32'(int_ovf), 0);
    check(buf_ovf == 1'b0, "R11 buf_ovf", 32'(buf_ovf), 0);
    check(buf_full == 2'b00, "R11 buf_full", 32'(buf_full), 0);

    // R10 capture disabled: no words
    ready_mode = 1; sample_mode = 1'b0;
    for (int i = 0; i < 10; i++) toggle(6);
    tick(20);
    check(ngot == 0, "R10 words while disabled", ngot, 0);

    // R2/R3 sample table walk under a stalling drain
    do_reset();
    ready_mode = 2; sample_mode = 1'b1; capture_en = 1'b1;
    for (int w = 0; w < 8; w++) begin
      if (w == 7) begin
        check(mem_valid == 1'b0, "R3 no offer before half full", 32'(mem_valid), 0);
        check(ngot == 0, "R3 no words before half full", ngot, 0);
      end
      for (int b = 0; b < 32; b++) push_sample(SAMPLE_VEC[w][b]);
    end
    tick(40);
    check(ngot == 8, "R3 half drained", ngot, 8);
    for (int w = 0; w < 8; w++)
      check(got[w] == SAMPLE_VEC[w], "R2 sample word", got[w], SAMPLE_VEC[w]);

    // R1 timestamps: differences equal transition spacing
    do_reset();
    ready_mode = 2; sample_mode = 1'b0; capture_en = 1'b1;
    for (int i = 0; i < 8; i++) toggle(GAP_VEC[i]);
    tick(40);
    check(ngot == 8, "R1 edge count", ngot, 8);
    for (int i = 1; i < 8; i++)
      check(got[i] - got[i-1] == 32'(GAP_VEC[i-1]), "R1 stamp delta",
            got[i] - got[i-1], 32'(GAP_VEC[i-1]));

    // R7 internal overrun and automatic resume
    do_reset();
    ready_mode = 0; auto_rel = 1'b1; sample_mode = 1'b0; capture_en = 1'b1;
    for (int i = 0; i < 19; i++) toggle(6);
    check(int_ovf == 1'b1, "R7 int_ovf set", 32'(int_ovf), 1);
    check(ngot == 0, "R4 nothing taken while stalled", ngot, 0);
    ready_mode = 1;
    tick(60);
    check(ngot == 16, "R7 extra words dropped", ngot, 16);
    check(int_ovf == 1'b1, "R9 int_ovf sticky", 32'(int_ovf), 1);
    for (int i = 0; i < 8; i++) toggle(6);
    tick(40);
    check(ngot == 24, "R7 resumed after drain", ngot, 24);
    int_ovf_clr = 1'b1; tick(1); int_ovf_clr = 1'b0; tick(1);
    check(int_ovf == 1'b0, "R9 int_ovf cleared", 32'(int_ovf), 0);

    // R5/R6/R8 buffer ring and buffer overrun
    do_reset();
    ready_mode = 1; auto_rel = 1'b0; sample_mode = 1'b0; capture_en = 1'b1;
    for (int i = 0; i < 32; i++) toggle(12);
    tick(30);
    check(buf_full == 2'b11, "R5 both buffers full", 32'(buf_full), 3);
    check(ngot == 32, "R5 words transferred", ngot, 32);
    check(buf_ovf == 1'b0, "R8 no overrun yet", 32'(buf_ovf), 0);
    for (int i = 0; i < 3; i++) toggle(12);
    check(buf_ovf == 1'b1, "R8 buf_ovf set", 32'(buf_ovf), 1);
    check(ngot == 32, "R8 words dropped", ngot, 32);
    check(mem_valid == 1'b0, "R5 no offer while blocked", 32'(mem_valid), 0);
    man_rel = 2'b01; tick(1); man_rel = 2'b00; tick(1);
    check(buf_full == 2'b10, "R6 buffer 0 released", 32'(buf_full), 2);
    for (int i = 0; i < 8; i++) toggle(12);
    tick(30);
    check(ngot == 40, "R8 resumed after release", ngot, 40);
    check(buf_ovf == 1'b1, "R9 buf_ovf sticky", 32'(buf_ovf), 1);
    buf_ovf_clr = 1'b1; tick(1); buf_ovf_clr = 1'b0; tick(1);
    check(buf_ovf == 1'b0, "R9 buf_ovf cleared", 32'(buf_ovf), 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule